// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block collects eight interrupt request lines, ranks them by fixed priority and raises a single interrupt line toward a processor. The processor talks to it through a byte-wide register port with one address bit. Address 0 takes commands and returns a status byte. Address 1 takes configuration words and the mask byte. When the processor acknowledges, the block answers with a vector byte. That byte is a programmed base plus the number of the winning input. The winning request also moves from the pending set into the in-service set, so that it blocks inputs of equal and lower priority until software ends it.

After reset the block stays silent until software writes a four-word setup sequence: a start command, the vector base, a cascade word and a mode word. The mode word can select automatic end-of-interrupt, in which case nothing is ever recorded as in service. Each block is either a master or a slave, chosen by a pin. A master with a slave behind one of its inputs does not answer for that input itself. It names the input on a cascade code output instead. A slave answers only when the cascade code presented to it equals the identity it was given during setup. When nothing is pending at acknowledge time, the block returns a spurious vector. That vector uses the number of the lowest-priority input, and no in-service bit is set.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, reading address 1 returns 0xFF (all inputs masked), and address-0 reads select the pending set. Until the setup sequence is complete, `int_out` stays 0 and an acknowledge produces neither `vec_valid` nor `cas_act`, whatever the mask.
- R2: A write to address 0 with bit 4 set starts setup. The next three writes to address 1 are the vector base, the cascade word and the mode word, in that order. Once setup is done, writes to address 1 load the mask (1 = input masked) and reads of address 1 return it.
- R3: The vector for input n is the base word with its low 3 bits replaced by n. Base 0x20 gives vectors 0x20 to 0x27, and base 0x28 gives 0x28 to 0x2F.
- R4: Input 0 has the highest priority. `int_out` is 1 only when an unmasked pending input has a smaller index than every in-service input. It follows a change of pending or in-service state within 2 clock cycles.
- R5: On an acknowledge (`inta_req` high for one cycle), the cycle after it carries a one-cycle `vec_valid` pulse with the vector of the winning input. The winner's pending bit is cleared, and its in-service bit is set.
- R6: When bit 1 of the mode word is 1 (mode word 0x03), an acknowledge sets no in-service bit. With mode word 0x01, in-service bits are recorded.
- R7: A command write of 0x60+n to address 0 clears in-service bit n and no other bit.
- R8: A command write of 0x0A makes later address-0 reads return the pending set, and 0x0B makes them return the in-service set. A setup start returns the selection to the pending set.
- R9: An acknowledge with no unmasked pending input returns base+7 and leaves the in-service set unchanged. This happens when a request was dropped before the acknowledge, and also when input 7 is masked.
- R10: A pending bit is set by a rising edge on its input and cleared when the input falls. An input held high after its acknowledge does not become pending again.
- R11: On a master (`is_master` = 1), acknowledging input n whose bit is 1 in the cascade word gives a one-cycle `cas_act` pulse with `cas_code` = n and no `vec_valid`. Input n is still set in service.
- R12: On a slave (`is_master` = 0), an acknowledge takes effect only when `cas_in` equals bits 2:0 of the cascade word. Otherwise no output pulses and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on `bus_rdata` after the next edge |
| bus_a0 | input | 1 | Register address bit |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_in | input | 8 | Interrupt request inputs, index 0 highest priority |
| int_out | output | 1 | Interrupt request to the processor |
| inta_req | input | 1 | Acknowledge request, one cycle |
| cas_in | input | 3 | Cascade code seen by a slave |
| vec_valid | output | 1 | One-cycle strobe marking `vec_out` |
| vec_out | output | 8 | Vector byte |
| cas_act | output | 1 | One-cycle strobe: a master hands the acknowledge to a slave |
| cas_code | output | 3 | Input number whose slave must answer |

## Verification
A wrong pending or in-service bit shows up at `int_out` within two cycles after the next request edge or end-of-interrupt. It also shows in the vector returned by the next acknowledge, and in the in-service readback one cycle after a read strobe. A wrong setup state reveals itself at once: either the data-address write lands in the mask instead of the configuration, or the vector base or cascade behaviour is wrong on the first acknowledge. The sweeps walk every input and every ordered pair of inputs, so a broken priority chain, a stray end-of-interrupt clear or a missing edge qualifier shows up as a wrong vector or readback byte.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } setup_st_e;

  localparam logic [2:0] EOI_SPEC_OP = 3'b011;
endpackage

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N_IN = 8,
  localparam int IW = $clog2(N_IN)
) (
  input  logic [N_IN-1:0] req,
  output logic [N_IN-1:0] win,
  output logic            found,
  output logic [IW-1:0]   idx
);
  logic [N_IN:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N_IN; g++) begin : g_chain
    assign win[g]      = req[g] & ~seen[g];
    assign seen[g + 1] = seen[g] | req[g];
  end

  assign found = seen[N_IN];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (win[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int DW   = 8,
  localparam int IW  = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic            bus_a0,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [N_IN-1:0] irr,
  input  logic [N_IN-1:0] isr,
  output logic [DW-1:0]   bus_rdata,
  output logic [N_IN-1:0] imr,
  output logic [DW-IW-1:0] base_hi,
  output logic [N_IN-1:0] cas_map,
  output logic [IW-1:0]   cas_id,
  output logic            aeoi,
  output logic            ready,
  output logic            setup_go,
  output logic            eoi_hit,
  output logic [IW-1:0]   eoi_idx
);
  setup_st_e st;
  logic      rd_isr;

  assign setup_go = bus_wr && !bus_a0 && bus_wdata[4];
  assign eoi_hit  = bus_wr && !bus_a0 && (bus_wdata[7:5] == EOI_SPEC_OP)
                    && (bus_wdata[4:3] == 2'b00);
  assign eoi_idx  = bus_wdata[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_RUN;
      ready   <= 1'b0;
      imr     <= '1;
      rd_isr  <= 1'b0;
      base_hi <= '0;
      cas_map <= '0;
      cas_id  <= '0;
      aeoi    <= 1'b0;
    end else if (bus_wr) begin
      if (!bus_a0) begin
        if (bus_wdata[4]) begin
          st     <= ST_BASE;
          ready  <= 1'b0;
          rd_isr <= 1'b0;
        end else if (bus_wdata[3] && bus_wdata[1]) begin
          rd_isr <= bus_wdata[0];
        end
      end else begin
        unique case (st)
          ST_BASE: begin
            base_hi <= bus_wdata[DW-1:IW];
            st      <= ST_CASC;
          end
          ST_CASC: begin
            cas_map <= bus_wdata[N_IN-1:0];
            cas_id  <= bus_wdata[IW-1:0];
            st      <= ST_MODE;
          end
          ST_MODE: begin
            aeoi  <= bus_wdata[1];
            ready <= 1'b1;
            st    <= ST_RUN;
          end
          default: imr <= bus_wdata[N_IN-1:0];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_a0)      bus_rdata <= DW'(imr);
      else if (rd_isr) bus_rdata <= DW'(isr);
      else             bus_rdata <= DW'(irr);
    end
  end

  AST_SETUP_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
    setup_go |=> !ready) else $error("setup start left block ready"); // R2
endmodule

// File: rtl/irqc_core.sv
module irqc_core #(
  parameter int N_IN = 8,
  parameter int DW   = 8,
  localparam int IW  = $clog2(N_IN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  irq_in,
  input  logic [N_IN-1:0]  imr,
  input  logic [DW-IW-1:0] base_hi,
  input  logic [N_IN-1:0]  cas_map,
  input  logic [IW-1:0]    cas_id,
  input  logic             aeoi,
  input  logic             ready,
  input  logic             is_master,
  input  logic             setup_go,
  input  logic             eoi_hit,
  input  logic [IW-1:0]    eoi_idx,
  input  logic             inta_req,
  input  logic [IW-1:0]    cas_in,
  output logic [N_IN-1:0]  irr,
  output logic [N_IN-1:0]  isr,
  output logic             int_out,
  output logic             vec_valid,
  output logic [DW-1:0]    vec_out,
  output logic             cas_act,
  output logic [IW-1:0]    cas_code
);
  logic [N_IN-1:0] irq_d;
  logic [N_IN:0]   isr_seen;
  logic [N_IN-1:0] pend;
  logic [N_IN-1:0] win;
  logic            found;
  logic [IW-1:0]   win_idx;
  logic            take;
  logic [N_IN-1:0] irr_clr;
  logic [N_IN-1:0] isr_set;
  logic [N_IN-1:0] isr_clr;

  assign isr_seen[0] = 1'b0;
  for (genvar g = 0; g < N_IN; g++) begin : g_isr_chain
    assign isr_seen[g + 1] = isr_seen[g] | isr[g];
  end

  assign pend = irr & ~imr & ~isr_seen[N_IN:1];

  irqc_prio #(.N_IN(N_IN)) u_prio (
    .req   (pend),
    .win   (win),
    .found (found),
    .idx   (win_idx)
  );

  assign take    = inta_req && ready && (is_master || (cas_in == cas_id));
  assign irr_clr = (take && found) ? win : '0;
  assign isr_set = (take && found && !aeoi) ? win : '0;
  assign isr_clr = eoi_hit ? (N_IN'(1) << eoi_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_d <= '0;
      irr   <= '0;
      isr   <= '0;
    end else begin
      irq_d <= irq_in;
      irr   <= irq_in & (irr | ~irq_d) & ~irr_clr;
      if (setup_go) isr <= '0;
      else          isr <= (isr | isr_set) & ~isr_clr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_out   <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
      cas_act   <= 1'b0;
      cas_code  <= '0;
    end else begin
      int_out   <= ready && found;
      vec_valid <= 1'b0;
      cas_act   <= 1'b0;
      if (take) begin
        if (found && is_master && ((win & cas_map) != '0)) begin
          cas_act  <= 1'b1;
          cas_code <= win_idx;
        end else begin
          vec_valid <= 1'b1;
          vec_out   <= {base_hi, (found ? win_idx : IW'(N_IN - 1))};
        end
      end
    end
  end

  AST_QUIET_UNTIL_SETUP: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !int_out) else $error("interrupt raised before setup"); // R1
  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(inta_req)) else $error("vector without acknowledge"); // R5
  AST_ISR_SET_BY_ACK: assert property (@(posedge clk) disable iff (rst)
    ((isr & ~$past(isr)) != '0) |-> $past(inta_req)) else $error("in-service set without acknowledge"); // R5
  AST_AEOI_NO_ISR: assert property (@(posedge clk) disable iff (rst)
    aeoi |-> (isr == '0)) else $error("in-service bit under auto end"); // R6
  AST_EOI_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $past(eoi_hit) |-> ($countones($past(isr) & ~isr) <= 1)) else $error("end cleared several bits"); // R7
  AST_CAS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(vec_valid && cas_act)) else $error("vector and cascade together"); // R11
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(inta_req) && !$past(is_master) && ($past(cas_in) != $past(cas_id)))
      |-> (!vec_valid && !cas_act)) else $error("slave answered foreign code"); // R12
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_IN = 8,
  parameter int DW   = 8,
  localparam int IW  = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            is_master,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic            bus_a0,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [N_IN-1:0] irq_in,
  output logic            int_out,
  input  logic            inta_req,
  input  logic [IW-1:0]   cas_in,
  output logic            vec_valid,
  output logic [DW-1:0]   vec_out,
  output logic            cas_act,
  output logic [IW-1:0]   cas_code
);
  logic [N_IN-1:0]  imr;
  logic [N_IN-1:0]  irr;
  logic [N_IN-1:0]  isr;
  logic [DW-IW-1:0] base_hi;
  logic [N_IN-1:0]  cas_map;
  logic [IW-1:0]    cas_id;
  logic             aeoi;
  logic             ready;
  logic             setup_go;
  logic             eoi_hit;
  logic [IW-1:0]    eoi_idx;

  irqc_regs #(.N_IN(N_IN), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_a0    (bus_a0),
    .bus_wdata (bus_wdata),
    .irr       (irr),
    .isr       (isr),
    .bus_rdata (bus_rdata),
    .imr       (imr),
    .base_hi   (base_hi),
    .cas_map   (cas_map),
    .cas_id    (cas_id),
    .aeoi      (aeoi),
    .ready     (ready),
    .setup_go  (setup_go),
    .eoi_hit   (eoi_hit),
    .eoi_idx   (eoi_idx)
  );

  irqc_core #(.N_IN(N_IN), .DW(DW)) u_core (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .imr       (imr),
    .base_hi   (base_hi),
    .cas_map   (cas_map),
    .cas_id    (cas_id),
    .aeoi      (aeoi),
    .ready     (ready),
    .is_master (is_master),
    .setup_go  (setup_go),
    .eoi_hit   (eoi_hit),
    .eoi_idx   (eoi_idx),
    .inta_req  (inta_req),
    .cas_in    (cas_in),
    .irr       (irr),
    .isr       (isr),
    .int_out   (int_out),
    .vec_valid (vec_valid),
    .vec_out   (vec_out),
    .cas_act   (cas_act),
    .cas_code  (cas_code)
  );
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       is_master = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_a0 = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] irq_in = '0;
  logic       int_out;
  logic       inta_req = 1'b0;
  logic [2:0] cas_in = '0;
  logic       vec_valid;
  logic [7:0] vec_out;
  logic       cas_act;
  logic [2:0] cas_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst(rst), .is_master(is_master),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_a0(bus_a0),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .int_out(int_out), .inta_req(inta_req),
    .cas_in(cas_in), .vec_valid(vec_valid), .vec_out(vec_out),
    .cas_act(cas_act), .cas_code(cas_code)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_wr = 1'b1; bus_a0 = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_rd = 1'b1; bus_a0 = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_isr(output logic [7:0] d);
    wr(1'b0, 8'h0B);
    rd(1'b0, d);
  endtask

  task automatic rd_irr(output logic [7:0] d);
    wr(1'b0, 8'h0A);
    rd(1'b0, d);
  endtask

  task automatic ack(input logic [2:0] c, output logic vv, output logic [7:0] v,
                     output logic ca, output logic [2:0] cc);
    inta_req = 1'b1; cas_in = c;
    @(negedge clk);
    inta_req = 1'b0;
    vv = vec_valid; v = vec_out; ca = cas_act; cc = cas_code;
  endtask

  task automatic setup(input logic [7:0] base, input logic [7:0] casw, input logic [7:0] mode);
    wr(1'b0, 8'h11);
    wr(1'b1, base);
    wr(1'b1, casw);
    wr(1'b1, mode);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       vv;
    logic [7:0] v;
    logic       ca;
    logic [2:0] cc;

    idle(3);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    rd(1'b1, d);
    chk("R1 mask after reset", d, 8'hFF);
    wr(1'b1, 8'h00);
    irq_in = 8'h01;
    idle(3);
    chk("R1 no int before setup", int_out, 0);
    ack(3'd0, vv, v, ca, cc);
    chk("R1 no vector before setup", {vv, ca}, 0);
    irq_in = 8'h00;
    idle(2);

    // R2: master setup, slave on input 2
    is_master = 1'b1;
    setup(8'h20, 8'h04, 8'h01);
    wr(1'b1, 8'h00);
    rd(1'b1, d);
    chk("R2 mask readback", d, 8'h00);

    // sweep every input
    for (int n = 0; n < 8; n++) begin
      irq_in = 8'(1 << n);
      idle(3);
      chk($sformatf("R4 int for input %0d", n), int_out, 1);
      ack(3'd0, vv, v, ca, cc);
      if (n == 2) begin
        chk("R11 cascade strobe", {ca, vv}, 2'b10);
        chk("R11 cascade code", cc, 2);
      end else begin
        chk($sformatf("R5 valid input %0d", n), vv, 1);
        chk($sformatf("R3 vector input %0d", n), v, 8'h20 + n);
      end
      rd_isr(d);
      chk($sformatf("R5 isr input %0d", n), d, 1 << n);
      rd_irr(d);
      chk($sformatf("R10 irr after ack input %0d", n), d, 0);
      chk($sformatf("R10 no re-raise input %0d", n), int_out, 0);
      wr(1'b0, 8'(8'h60 + n));
      rd_isr(d);
      chk($sformatf("R7 eoi input %0d", n), d, 0);
      irq_in = 8'h00;
      idle(2);
    end

    // R4/R7: ordered pairs, excluding cascaded input 2
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        if (i == 2 || j == 2) continue;
        irq_in = 8'(1 << j);
        idle(3);
        ack(3'd0, vv, v, ca, cc);
        chk("R4 single low vector", v, 8'h20 + j);
        irq_in = irq_in | 8'(1 << i);
        idle(3);
        chk("R4 higher nests over lower", int_out, 1);
        ack(3'd0, vv, v, ca, cc);
        chk("R4 nested vector", v, 8'h20 + i);
        rd_isr(d);
        chk("R5 both in service", d, (1 << i) | (1 << j));
        wr(1'b0, 8'(8'h60 + i));
        rd_isr(d);
        chk("R7 clears only one", d, 1 << j);
        wr(1'b0, 8'(8'h60 + j));
        irq_in = 8'h00;
        idle(2);
        irq_in = 8'((1 << i) | (1 << j));
        idle(3);
        ack(3'd0, vv, v, ca, cc);
        chk("R4 winner of pair", v, 8'h20 + i);
        idle(2);
        chk("R4 lower blocked by in service", int_out, 0);
        wr(1'b0, 8'(8'h60 + i));
        idle(2);
        chk("R4 lower raised after eoi", int_out, 1);
        ack(3'd0, vv, v, ca, cc);
        chk("R4 second of pair", v, 8'h20 + j);
        wr(1'b0, 8'(8'h60 + j));
        irq_in = 8'h00;
        idle(2);
      end
    end

    // R2/R9: masked request, acknowledge is spurious
    wr(1'b1, 8'h08);
    rd(1'b1, d);
    chk("R2 mask value", d, 8'h08);
    irq_in = 8'h08;
    idle(3);
    chk("R2 masked input silent", int_out, 0);
    ack(3'd0, vv, v, ca, cc);
    chk("R9 spurious under mask", {7'(0), vv, v}, {7'(0), 1'b1, 8'h27});
    rd_isr(d);
    chk("R9 no isr on spurious", d, 0);
    irq_in = 8'h00;
    wr(1'b1, 8'h00);
    idle(2);

    // R9: request withdrawn before acknowledge, input 7 masked too
    irq_in = 8'h20;
    idle(3);
    irq_in = 8'h00;
    wr(1'b1, 8'h80);
    idle(2);
    ack(3'd0, vv, v, ca, cc);
    chk("R9 withdrawn request vector", v, 8'h27);
    chk("R9 withdrawn request valid", vv, 1);
    rd_isr(d);
    chk("R9 isr unchanged", d, 0);
    wr(1'b1, 8'h00);

    // R10: new edge after a fall raises again
    irq_in = 8'h10;
    idle(3);
    ack(3'd0, vv, v, ca, cc);
    wr(1'b0, 8'h64);
    idle(3);
    chk("R10 held input not pending", int_out, 0);
    irq_in = 8'h00;
    idle(2);
    irq_in = 8'h10;
    idle(3);
    chk("R10 new edge pending", int_out, 1);
    rd_irr(d);
    chk("R8 irr readback", d, 8'h10);
    ack(3'd0, vv, v, ca, cc);
    wr(1'b0, 8'h64);
    irq_in = 8'h00;
    idle(2);

    // R6/R8: automatic end, new base; setup resets readback choice
    wr(1'b0, 8'h0B);
    setup(8'h28, 8'h04, 8'h03);
    irq_in = 8'h40;
    idle(3);
    rd(1'b0, d);
    chk("R8 setup restores irr readback", d, 8'h40);
    ack(3'd0, vv, v, ca, cc);
    chk("R3 vector with base 0x28", v, 8'h2E);
    rd_isr(d);
    chk("R6 auto end leaves isr clear", d, 0);
    irq_in = 8'h00;
    idle(2);

    // R12: slave with identity 2
    is_master = 1'b0;
    setup(8'h28, 8'h02, 8'h01);
    wr(1'b1, 8'h00);
    irq_in = 8'h02;
    idle(3);
    ack(3'd3, vv, v, ca, cc);
    chk("R12 foreign code ignored", {vv, ca}, 0);
    rd_isr(d);
    chk("R12 isr untouched", d, 0);
    ack(3'd2, vv, v, ca, cc);
    chk("R12 own code answers", {7'(0), vv, v}, {7'(0), 1'b1, 8'h29});
    rd_isr(d);
    chk("R12 isr set", d, 8'h02);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule